// File: doc/BRIEF.md
# Scheduled Front-End Clock Starter

This block holds a divided front-end clock stopped until a chosen moment and then lets it run. The moment is given as an absolute value of a free-running system timestamp that advances once per 10 ns system clock cycle. Host software first writes a 48-bit target timestamp through a small word-wide register port and then sets an enable bit. While the block is armed it compares the live timestamp with the target on every cycle. The first compare that finds the live value greater than or equal to the target starts the divided clock after a fixed latency.

When the clock starts, the block stores the three lowest bits of the timestamp from the compare cycle in a status word. Software can read these bits from every module that was started the same way. Equal values across modules show that they all started on the same tick. If the target has already passed when the block is armed, a late flag is set and the clock starts as soon as the pipeline allows.

Register map (word address on `cfg_addr` / `cfg_raddr`): 0 = target bits [31:0], 1 = target bits [47:32] in data bits [15:0], 2 = control (bit 0 = enable), 3 = status (read only).

Top module: `ts_sched_clk_start`

## Requirements
- R1: After synchronous reset the block is idle. `fe_clk` is 0, the status word reads 0, and the target and control words read back as 0.
- R2: Writing address 0 loads target bits [31:0]. Writing address 1 loads target bits [47:32] from data bits [15:0]. Both read back at the same addresses. The control word reads back the last value written to its bit 0.
- R3: Writing control bit 0 = 1 while idle moves the block to the armed state at that clock edge. Status bit 0 (armed) then reads 1. Writing 1 while already armed or running changes nothing.
- R4: Let e be the first clock edge at which the block is armed and the sampled timestamp is >= the target. At edge e+1 the block enters running: status bit 1 reads 1, bit 0 reads 0, and `fe_clk` is 1 from that edge. With a late arm written at edge a, this gives e = a+1 and running from a+2.
- R5: The compare is an unsigned compare over all 48 bits and uses >=. If the timestamp jumps over the exact target value, the clock still starts at the first sampled value above it. A target whose low word is below the current low word does not start the clock early when the high word is larger.
- R6: Status bits [6:4] hold timestamp bits [2:0] as sampled at edge e. Arming clears them to 0, and they keep their value after a disable.
- R7: Status bit 2 (late) is loaded at each arm. It is set to 1 when the timestamp sampled at the arming edge is already >= the target, and to 0 otherwise.
- R8: Writes to addresses 0 and 1 are ignored unless the block is idle. The stored target and the start instant are unchanged.
- R9: Writing control bit 0 = 0 returns the block to idle at that edge from any state. `fe_clk` is 0 and status bits 0 and 1 read 0 from then on. The late flag and the captured bits are kept.
- R10: With divide ratio DIV (even, default 4), `fe_clk` is 1 for the first DIV/2 cycles of each DIV-cycle period, counted from entry into running. The default output pattern is therefore 1,1,0,0 repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one timestamp tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ts_now | input | TS_W (48) | Live system timestamp |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register write address |
| cfg_wdata | input | DW (32) | Register write data |
| cfg_raddr | input | 2 | Register read address |
| cfg_rdata | output | DW (32) | Register read data (combinational) |
| fe_clk | output | 1 | Gated, divided front-end clock |

## Verification
The bench places the target just above a 32-bit carry of the timestamp. A compare that looked only at the low word would start about a hundred cycles early there. It then lets the timestamp advance by three per cycle so that equality never occurs, which catches an equality-only compare that never starts. It arms with a target already in the past to check the late flag and the two-cycle start latency, rewrites the target while armed to catch a register that is not frozen, and disables from both waiting and running to check that the gate closes at once while the captured bits survive. A behavioural model predicts `fe_clk` and the status word on every cycle, so a divider that restarts with the wrong phase or a capture taken one cycle off shows up as a mismatch.

// File: rtl/tsck_pkg.sv
package tsck_pkg;

    localparam int CAP_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } tsck_state_e;

    localparam logic [1:0] A_TGT_LO = 2'd0;
    localparam logic [1:0] A_TGT_HI = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_STAT   = 2'd3;

    typedef struct packed {
        logic [CAP_W-1:0] cap;
        logic             late;
        logic             running;
        logic             armed;
    } tsck_stat_t;

    function automatic logic [7:0] stat_byte(tsck_stat_t s);
        return {1'b0, s.cap, 1'b0, s.late, s.running, s.armed};
    endfunction

endpackage

// File: rtl/tsck_regs.sv
module tsck_regs import tsck_pkg::*; #(
    parameter int TS_W = 48,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [1:0]      waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [1:0]      raddr,
    input  logic            idle,
    input  tsck_stat_t      stat,
    output logic [TS_W-1:0] target,
    output logic            arm_req,
    output logic            dis_req,
    output logic [DW-1:0]   rdata
);
    localparam int HI_W = TS_W - DW;

    logic [TS_W-1:0] target_q;
    logic            en_q;
    logic            unused_wdata;

    assign unused_wdata = ^wdata;
    assign target  = target_q;
    assign arm_req = wr && (waddr == A_CTRL) &&  wdata[0];
    assign dis_req = wr && (waddr == A_CTRL) && !wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            en_q     <= 1'b0;
        end else if (wr) begin
            if (waddr == A_TGT_LO && idle) target_q[DW-1:0]    <= wdata;
            if (waddr == A_TGT_HI && idle) target_q[TS_W-1:DW] <= wdata[HI_W-1:0];
            if (waddr == A_CTRL)           en_q                <= wdata[0];
        end
    end

    always_comb begin
        unique case (raddr)
            A_TGT_LO: rdata = target_q[DW-1:0];
            A_TGT_HI: rdata = {{(DW-HI_W){1'b0}}, target_q[TS_W-1:DW]};
            A_CTRL:   rdata = {{(DW-1){1'b0}}, en_q};
            default:  rdata = {{(DW-8){1'b0}}, stat_byte(stat)};
        endcase
    end

    // R8: the target does not move while the block is armed or running
    assert_target_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && (waddr == A_TGT_LO || waddr == A_TGT_HI) && !idle) |=> $stable(target_q))
        else $error("target changed outside idle");

endmodule

// File: rtl/tsck_cmp.sv
module tsck_cmp import tsck_pkg::*; #(
    parameter int TS_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [TS_W-1:0]  ts_now,
    input  logic [TS_W-1:0]  target,
    output logic             ge_now,
    output logic             hit_q,
    output logic [CAP_W-1:0] lsb_q
);
    assign ge_now = (ts_now >= target);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            lsb_q <= '0;
        end else begin
            hit_q <= active && ge_now;
            lsb_q <= ts_now[CAP_W-1:0];
        end
    end

    // R5: a registered hit always comes from a cycle whose timestamp reached the target
    assert_hit_has_reached_R5: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> $past(ts_now >= target))
        else $error("compare hit without timestamp >= target");

endmodule

// File: rtl/tsck_div.sv
module tsck_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic clk_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    generate
        if (DIV == 2) begin : g_toggle
            always_ff @(posedge clk) begin
                if (rst)        clk_o <= 1'b0;
                else if (start) clk_o <= 1'b1;
                else if (run)   clk_o <= !clk_o;
                else            clk_o <= 1'b0;
            end
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            logic [CW-1:0] cnt_n;
            assign cnt_n = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                    clk_o <= 1'b0;
                end else if (start) begin
                    cnt_q <= '0;
                    clk_o <= 1'b1;
                end else if (run) begin
                    cnt_q <= cnt_n;
                    clk_o <= (cnt_n < CW'(HALF));
                end else begin
                    cnt_q <= '0;
                    clk_o <= 1'b0;
                end
            end
        end
    endgenerate

    // R10: the first divided cycle is high right after the start edge
    assert_first_phase_high_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> clk_o)
        else $error("divided clock did not begin high");

    // R9: the output is held low whenever the divider is not running
    assert_gate_closed_R9: assert property (@(posedge clk) disable iff (rst)
        (!start && !run) |=> !clk_o)
        else $error("divided clock leaked while stopped");

endmodule

// File: rtl/ts_sched_clk_start.sv
module ts_sched_clk_start import tsck_pkg::*; #(
    parameter int TS_W = 48,
    parameter int DW   = 32,
    parameter int DIV  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TS_W-1:0] ts_now,
    input  logic            cfg_wr,
    input  logic [1:0]      cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic [1:0]      cfg_raddr,
    output logic [DW-1:0]   cfg_rdata,
    output logic            fe_clk
);
    tsck_state_e      st_q, st_d;
    logic             arm_req, dis_req, arm, start, run_keep, idle;
    logic             ge_now, hit_q, late_q;
    logic [CAP_W-1:0] lsb_q, cap_q;
    logic [TS_W-1:0]  target;
    tsck_stat_t       stat;

    assign idle     = (st_q == ST_IDLE);
    assign arm      = arm_req && idle;
    assign start    = (st_q == ST_ARMED) && hit_q && !dis_req;
    assign run_keep = (st_q == ST_RUN) && !dis_req;

    always_comb begin
        st_d = st_q;
        if (dis_req)    st_d = ST_IDLE;
        else if (arm)   st_d = ST_ARMED;
        else if (start) st_d = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            late_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            st_q <= st_d;
            if (arm) begin
                late_q <= ge_now;
                cap_q  <= '0;
            end else if (start) begin
                cap_q <= lsb_q;
            end
        end
    end

    always_comb begin
        stat.cap     = cap_q;
        stat.late    = late_q;
        stat.running = (st_q == ST_RUN);
        stat.armed   = (st_q == ST_ARMED);
    end

    tsck_regs #(.TS_W(TS_W), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr(cfg_wr), .waddr(cfg_addr), .wdata(cfg_wdata),
        .raddr(cfg_raddr), .idle(idle), .stat(stat), .target(target),
        .arm_req(arm_req), .dis_req(dis_req), .rdata(cfg_rdata)
    );

    tsck_cmp #(.TS_W(TS_W)) u_cmp (
        .clk(clk), .rst(rst), .active((st_q == ST_ARMED) && !dis_req),
        .ts_now(ts_now), .target(target), .ge_now(ge_now),
        .hit_q(hit_q), .lsb_q(lsb_q)
    );

    tsck_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .start(start), .run(run_keep), .clk_o(fe_clk)
    );

    // R3: an enable write while idle arms the block at that edge
    assert_arm_R3: assert property (@(posedge clk) disable iff (rst)
        (arm_req && idle) |=> (st_q == ST_ARMED))
        else $error("enable did not arm");

    // R4: a hit seen while armed leads to running on the next edge
    assert_start_after_hit_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_ARMED) && hit_q && !dis_req) |=> (st_q == ST_RUN))
        else $error("armed hit did not start the clock");

    // R6: captured bits are the timestamp bits from the compare edge
    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_RUN) |-> (cap_q == $past(ts_now[CAP_W-1:0], 2)))
        else $error("captured timestamp bits are wrong");

    // R7: the late flag reflects the compare at the arming edge
    assert_late_R7: assert property (@(posedge clk) disable iff (rst)
        (arm_req && idle) |=> (late_q == $past(ts_now >= target)))
        else $error("late flag wrong after arm");

    // R9: a disable write always returns the block to idle
    assert_disable_R9: assert property (@(posedge clk) disable iff (rst)
        dis_req |=> (st_q == ST_IDLE))
        else $error("disable did not reach idle");

endmodule

// File: tb/test_ts_sched_clk_start.sv
module test_ts_sched_clk_start;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] ts_now = 48'h0000_FFFF_FF80;
    int          step = 1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_raddr = 2'd3;
    logic [31:0] cfg_rdata;
    logic        fe_clk;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = !clk;

    always @(negedge clk) begin
        #1;
        ts_now <= ts_now + 48'(step);
    end

    ts_sched_clk_start i_ts_sched_clk_start (
        .clk(clk), .rst(rst), .ts_now(ts_now), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .fe_clk(fe_clk)
    );

    // behavioural reference: state 0 idle, 1 waiting, 2 running
    int          m_st;
    logic [47:0] m_tgt;
    logic        m_en, m_late, m_pend, m_clk;
    logic [2:0]  m_cap, m_plsb;
    int          m_ph;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_tgt = '0; m_en = 0; m_late = 0; m_pend = 0;
            m_clk = 0; m_cap = '0; m_plsb = '0; m_ph = 0;
        end else begin
            if (cfg_wr && cfg_addr == 2'd2) m_en = cfg_wdata[0];
            if (cfg_wr && cfg_addr == 2'd2 && !cfg_wdata[0]) begin
                m_st = 0; m_pend = 0; m_clk = 0;
            end else if (cfg_wr && cfg_addr == 2'd2 && m_st == 0) begin
                m_st = 1; m_cap = '0; m_late = (ts_now >= m_tgt); m_pend = 0;
            end else if (m_st == 1) begin
                if (m_pend) begin
                    m_st = 2; m_cap = m_plsb; m_ph = 0; m_clk = 1;
                end
                m_pend = (ts_now >= m_tgt);
                m_plsb = ts_now[2:0];
            end else if (m_st == 2) begin
                m_ph = m_ph + 1;
                m_clk = ((m_ph % 4) < 2);
            end else begin
                m_pend = 0;
            end
            if (cfg_wr && cfg_addr == 2'd0 && m_st == 0 && !(m_st == 1)) m_tgt[31:0] = cfg_wdata;
            if (cfg_wr && cfg_addr == 2'd1 && m_st == 0) m_tgt[47:32] = cfg_wdata[15:0];
        end
    end
    // note: target writes above use the state after this edge; arm and target never share a cycle

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 fe_clk per cycle", 64'(fe_clk), 64'(m_clk));
            if (cfg_raddr == 2'd3)
                chk("R3 status per cycle", 64'(cfg_rdata),
                    64'({25'd0, m_cap, 1'b0, m_late, (m_st == 2), (m_st == 1)}));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); #2;
        cfg_wr = 1'b0;
    endtask

    task automatic rdchk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #2;
        cfg_raddr = a;
        @(negedge clk);
        chk(tag, 64'(cfg_rdata), 64'(exp));
        #2 cfg_raddr = 2'd3;
    endtask

    task automatic wait_high(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (fe_clk !== 1'b1 && n < 1000);
    endtask

    task automatic set_target(input logic [47:0] t);
        wr(2'd0, t[31:0]);
        wr(2'd1, {16'd0, t[47:32]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int          n;
        logic [47:0] t0, tgt;
        logic [7:0]  pat;
        repeat (3) @(posedge clk);
        @(negedge clk); #2 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 fe_clk", 64'(fe_clk), 64'd0);
        chk("R1 status", 64'(cfg_rdata), 64'd0);
        rdchk(2'd0, 32'd0, "R1 target lo");
        rdchk(2'd2, 32'd0, "R1 control");

        // R2 target across a 32-bit carry, R5 full-width compare
        set_target(48'h0001_0000_0005);
        rdchk(2'd0, 32'h0000_0005, "R2 target lo");
        rdchk(2'd1, 32'h0000_0001, "R2 target hi");
        wr(2'd2, 32'd1);
        @(negedge clk);
        chk("R3 armed bit", 64'(cfg_rdata[1:0]), 64'd1);
        rdchk(2'd2, 32'd1, "R2 control readback");
        wait_high(n);
        chk("R5 start instant above carry", 64'(ts_now), 64'h0001_0000_0006);
        chk("R4 running bits", 64'(cfg_rdata[1:0]), 64'd2);
        chk("R6 captured bits", 64'(cfg_rdata[6:4]), 64'd5);
        chk("R7 not late", 64'(cfg_rdata[2]), 64'd0);
        pat = {7'd0, fe_clk};
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            pat = {pat[6:0], fe_clk};
        end
        chk("R10 divided pattern", 64'(pat), 64'hCC);

        // R9 disable from running keeps capture
        wr(2'd2, 32'd0);
        @(negedge clk);
        chk("R9 gate closed", 64'(fe_clk), 64'd0);
        chk("R9 status after disable", 64'(cfg_rdata), 64'h50);

        // R8 target frozen while armed
        @(negedge clk);
        tgt = ts_now + 48'd300;
        set_target(tgt);
        wr(2'd2, 32'd1);
        @(negedge clk);
        chk("R6 capture cleared on arm", 64'(cfg_rdata[6:4]), 64'd0);
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd0);
        rdchk(2'd0, tgt[31:0], "R8 target lo unchanged");
        rdchk(2'd1, {16'd0, tgt[47:32]}, "R8 target hi unchanged");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (fe_clk !== 1'b0) chk("R8 no early start", 64'(fe_clk), 64'd0);
        end
        chk("R8 still armed", 64'(cfg_rdata[1:0]), 64'd1);
        wr(2'd2, 32'd0);
        @(negedge clk);
        chk("R9 disarmed", 64'(cfg_rdata[1:0]), 64'd0);

        // R5 exact target value skipped by a stride of 3
        step = 3;
        @(negedge clk);
        @(negedge clk);
        t0 = ts_now;
        set_target(t0 + 48'd61);
        wr(2'd2, 32'd1);
        wait_high(n);
        chk("R5 start after skipped equality", 64'(ts_now), 64'(t0 + 48'd66));
        chk("R6 captured bits stride", 64'(cfg_rdata[6:4]), 64'((t0 + 48'd63) & 48'd7));
        wr(2'd2, 32'd0);
        step = 1;

        // R7 late arm and R4 fixed latency
        @(negedge clk);
        @(negedge clk);
        t0 = ts_now;
        set_target(t0 - 48'd10);
        wr(2'd2, 32'd1);
        wait_high(n);
        chk("R4 late start latency", 64'(n), 64'd2);
        chk("R7 late flag set", 64'(cfg_rdata[2]), 64'd1);
        wr(2'd2, 32'd0);
        @(negedge clk);
        set_target(ts_now + 48'd500);
        wr(2'd2, 32'd1);
        @(negedge clk);
        chk("R7 late flag cleared on re-arm", 64'(cfg_rdata[2]), 64'd0);
        chk("R6 capture cleared on re-arm", 64'(cfg_rdata[6:4]), 64'd0);
        wr(2'd2, 32'd1);
        @(negedge clk);
        chk("R3 second enable no effect", 64'(cfg_rdata[1:0]), 64'd1);
        wr(2'd2, 32'd0);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule